// File: doc/BRIEF.md
# Serial ADC Read Controller

This block is a host-side master for a 12-bit serial sampling converter that returns its result in two's complement. A one-cycle start request pulls chip select low. The block then generates a divided serial clock and captures the serial data line on each rising serial clock edge. It reads a leading zero marker bit and the 12-bit word, most significant bit first. When the echo check is enabled it also reads the trailing copy of the word, which comes least significant bit first, and compares that copy with the word it already holds.

When the read is complete, the serial clock returns low and chip select goes high, which lets the converter drop into its low-power state. One cycle later the block pulses a valid strobe. With the strobe it presents the raw 12-bit code, a 16-bit sign-extended copy of that code, and an error flag. The error flag reports a marker bit that was high or an echo that did not match the word.

The host chooses the serial clock rate through a divider input. It must keep that rate at or below what the converter accepts, which is 3.2 MHz.

Top module: `sadc_read_ctrl`

## Requirements
- R1: While reset is asserted and right after it, chip select is high, the serial clock is low, valid and error are low, and both results are zero.
- R2: A start pulse seen while idle drives chip select low on the next clock edge. A start pulse during a read, or during its completion cycle, is ignored: chip select stays low and the read still produces exactly one valid pulse.
- R3: Each serial clock phase, high or low, lasts div_i+1 system clock cycles. The divider value is captured at start. The serial clock is low whenever chip select is high.
- R4: Serial data is sampled on rising serial clock edges, counted from 1 after chip select falls. The value sampled on edge 3 is the marker bit. A 1 there sets the error flag reported with that read.
- R5: Rising edges 4 through 15 capture bits 11 down to 0 of the word, most significant first. That word appears on result_o.
- R6: With echo_en_i high at start, the read has 26 rising edges, and edges 16 through 26 are compared with word bits 1 through 11 in that order. Any difference sets the error flag. With echo_en_i low at start, the read has 15 rising edges and no bits after edge 15 are examined.
- R7: result_sx_o equals result_o with bit 11 copied into bits 15:12. Examples: 0x7FF gives 0x07FF (positive full scale), 0x800 gives 0xF800 (negative full scale), 0xFFF gives 0xFFFF, and 0x000 gives 0x0000.
- R8: After the last rising edge, the serial clock falls and chip select rises on the same system clock edge. valid_o is high for exactly one cycle, on the cycle after chip select rises. result_o, result_sx_o and err_o take their new values at that moment and hold them until the next valid pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle read request |
| div_i | input | DIV_W | Serial clock half-period minus one, in system cycles |
| echo_en_i | input | 1 | Enable reading and comparing the LSB-first echo |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock |
| result_o | output | 12 | Captured two's-complement code |
| result_sx_o | output | 16 | Sign-extended code |
| valid_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Marker or echo mismatch for the reported read |

## Verification
The assertions assume the following about the inputs:
- sdata_i changes only after falling serial clock edges and holds steady through the next rising edge.
- div_i and echo_en_i are valid in the cycle that start_i is accepted.

The bench's converter model is clocked by the falling edges of sclk_o. It resets its bit counter whenever chip select rises. Stimulus is driven on falling system clock edges only, so sdata_i never changes in the cycle in which the controller samples it. The model can also inject a high marker bit or a flipped echo bit.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
    localparam int WORD_W    = 12;
    localparam int EXT_W     = 16;
    localparam int NULL_EDGE = 3;
    localparam int MSB_EDGE  = NULL_EDGE + 1;
    localparam int LSB_EDGE  = MSB_EDGE + WORD_W - 1;
    localparam int ECHO_LAST = LSB_EDGE + WORD_W - 1;
    localparam int EDGE_W    = $clog2(ECHO_LAST + 1);
    localparam int IDX_W     = $clog2(WORD_W);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } rd_state_e;
endpackage

// File: rtl/sadc_clkgen.sv
module sadc_clkgen #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             sclk_o,
    output logic             rise_o,
    output logic             fall_o
);
    typedef struct packed {
        logic [DIV_W-1:0] phase;
        logic             sclk;
    } cg_t;

    cg_t  cg_d, cg_q;
    logic wrap;

    always_comb begin
        cg_d   = cg_q;
        wrap   = (cg_q.phase == div_i);
        rise_o = run_i && wrap && !cg_q.sclk;
        fall_o = run_i && wrap && cg_q.sclk;
        if (!run_i) begin
            cg_d.phase = '0;
            cg_d.sclk  = 1'b0;
        end else if (wrap) begin
            cg_d.phase = '0;
            cg_d.sclk  = !cg_q.sclk;
        end else begin
            cg_d.phase = cg_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cg_q <= '0;
        else        cg_q <= cg_d;
    end

    assign sclk_o = cg_q.sclk;

    // R3
    sclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && (cg_q.phase != div_i)) |=> $stable(cg_q.sclk));
endmodule

// File: rtl/sadc_seq.sv
module sadc_seq #(
    parameter int DIV_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [DIV_W-1:0]          div_i,
    input  logic                      echo_en_i,
    input  logic                      rise_i,
    input  logic                      fall_i,
    output logic                      cs_n_o,
    output logic                      run_o,
    output logic [DIV_W-1:0]          div_o,
    output logic                      clr_o,
    output logic                      null_stb_o,
    output logic                      word_stb_o,
    output logic                      echo_stb_o,
    output logic [sadc_pkg::IDX_W-1:0] echo_idx_o,
    output logic                      publish_o
);
    import sadc_pkg::*;

    typedef struct packed {
        rd_state_e         state;
        logic [EDGE_W-1:0] edge_cnt;
        logic              cs_n;
        logic              run;
        logic [DIV_W-1:0]  div;
        logic              echo;
    } seq_t;

    seq_t              sq_d, sq_q;
    logic [EDGE_W-1:0] edge_n;
    logic [EDGE_W-1:0] last_edge;

    always_comb begin
        sq_d       = sq_q;
        clr_o      = 1'b0;
        publish_o  = 1'b0;
        edge_n     = sq_q.edge_cnt + 1'b1;
        last_edge  = sq_q.echo ? EDGE_W'(ECHO_LAST) : EDGE_W'(LSB_EDGE);
        null_stb_o = rise_i && (edge_n == EDGE_W'(NULL_EDGE));
        word_stb_o = rise_i && (edge_n >= EDGE_W'(MSB_EDGE))
                            && (edge_n <= EDGE_W'(LSB_EDGE));
        echo_stb_o = rise_i && (edge_n > EDGE_W'(LSB_EDGE));
        echo_idx_o = IDX_W'(edge_n - EDGE_W'(LSB_EDGE));
        case (sq_q.state)
            ST_IDLE: begin
                sq_d.cs_n = 1'b1;
                sq_d.run  = 1'b0;
                if (start_i) begin
                    sq_d.state    = ST_RUN;
                    sq_d.cs_n     = 1'b0;
                    sq_d.run      = 1'b1;
                    sq_d.edge_cnt = '0;
                    sq_d.div      = div_i;
                    sq_d.echo     = echo_en_i;
                    clr_o         = 1'b1;
                end
            end
            ST_RUN: begin
                if (rise_i) sq_d.edge_cnt = edge_n;
                if (fall_i && (sq_q.edge_cnt == last_edge)) begin
                    sq_d.state = ST_DONE;
                    sq_d.cs_n  = 1'b1;
                    sq_d.run   = 1'b0;
                end
            end
            ST_DONE: begin
                publish_o  = 1'b1;
                sq_d.state = ST_IDLE;
            end
            default: sq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q.state    <= ST_IDLE;
            sq_q.edge_cnt <= '0;
            sq_q.cs_n     <= 1'b1;
            sq_q.run      <= 1'b0;
            sq_q.div      <= '0;
            sq_q.echo     <= 1'b0;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign cs_n_o = sq_q.cs_n;
    assign run_o  = sq_q.run;
    assign div_o  = sq_q.div;

    // R6
    edge_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sq_q.edge_cnt <= EDGE_W'(ECHO_LAST));

    // R2
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.state == ST_RUN && start_i) |=> !sq_q.cs_n || (sq_q.state == ST_DONE));
endmodule

// File: rtl/sadc_dpath.sv
module sadc_dpath (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr_i,
    input  logic                       sdata_i,
    input  logic                       null_stb_i,
    input  logic                       word_stb_i,
    input  logic                       echo_stb_i,
    input  logic [sadc_pkg::IDX_W-1:0]  echo_idx_i,
    input  logic                       publish_i,
    output logic [sadc_pkg::WORD_W-1:0] result_o,
    output logic                       err_o,
    output logic                       valid_o
);
    import sadc_pkg::*;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              fault;
        logic [WORD_W-1:0] result;
        logic              err;
        logic              valid;
    } dp_t;

    dp_t dp_d, dp_q;

    always_comb begin
        dp_d       = dp_q;
        dp_d.valid = publish_i;
        if (clr_i) begin
            dp_d.word  = '0;
            dp_d.fault = 1'b0;
        end
        if (null_stb_i && sdata_i) dp_d.fault = 1'b1;
        if (word_stb_i) dp_d.word = {dp_q.word[WORD_W-2:0], sdata_i};
        if (echo_stb_i && (dp_q.word[echo_idx_i] != sdata_i)) dp_d.fault = 1'b1;
        if (publish_i) begin
            dp_d.result = dp_q.word;
            dp_d.err    = dp_q.fault;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign result_o = dp_q.result;
    assign err_o    = dp_q.err;
    assign valid_o  = dp_q.valid;

    // R5
    word_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!word_stb_i && !clr_i) |=> $stable(dp_q.word));

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !publish_i |=> ($stable(dp_q.result) && $stable(dp_q.err)));
endmodule

// File: rtl/sadc_read_ctrl.sv
module sadc_read_ctrl #(
    parameter int DIV_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [DIV_W-1:0]           div_i,
    input  logic                       echo_en_i,
    input  logic                       sdata_i,
    output logic                       cs_n_o,
    output logic                       sclk_o,
    output logic [sadc_pkg::WORD_W-1:0] result_o,
    output logic [sadc_pkg::EXT_W-1:0]  result_sx_o,
    output logic                       valid_o,
    output logic                       err_o
);
    import sadc_pkg::*;

    localparam int PAD_W = EXT_W - WORD_W;

    logic             run, rise, fall, clr;
    logic             null_stb, word_stb, echo_stb, publish;
    logic [DIV_W-1:0] div_l;
    logic [IDX_W-1:0] echo_idx;

    sadc_seq #(.DIV_W(DIV_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .div_i      (div_i),
        .echo_en_i  (echo_en_i),
        .rise_i     (rise),
        .fall_i     (fall),
        .cs_n_o     (cs_n_o),
        .run_o      (run),
        .div_o      (div_l),
        .clr_o      (clr),
        .null_stb_o (null_stb),
        .word_stb_o (word_stb),
        .echo_stb_o (echo_stb),
        .echo_idx_o (echo_idx),
        .publish_o  (publish)
    );

    sadc_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .div_i  (div_l),
        .sclk_o (sclk_o),
        .rise_o (rise),
        .fall_o (fall)
    );

    sadc_dpath u_dpath (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr),
        .sdata_i    (sdata_i),
        .null_stb_i (null_stb),
        .word_stb_i (word_stb),
        .echo_stb_i (echo_stb),
        .echo_idx_i (echo_idx),
        .publish_i  (publish),
        .result_o   (result_o),
        .err_o      (err_o),
        .valid_o    (valid_o)
    );

    assign result_sx_o = {{PAD_W{result_o[WORD_W-1]}}, result_o};

    // R3
    cs_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

    // R8
    valid_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (cs_n_o && $past(cs_n_o)));

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
endmodule

// File: tb/sadc_read_ctrl_bench.sv
module sadc_read_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 4;
    localparam int NVEC       = 8;
    // packing: [11:0] word, [13:12] div, [14] echo, [15] bad marker, [16] echo flip, [17] expected error
    localparam logic [17:0] VEC [NVEC] = '{
        18'h057FF, 18'h00800, 18'h06000, 18'h03FFF,
        18'h35A5C, 18'h283C3, 18'h115A5, 18'h2C123
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [DIV_W-1:0] div_i = '0;
    logic             echo_en_i = 1'b0;
    logic             sdata_i = 1'b1;
    logic             cs_n_o, sclk_o, valid_o, err_o;
    logic [11:0]      result_o;
    logic [15:0]      result_sx_o;

    sadc_read_ctrl #(.DIV_W(DIV_W)) u_sadc_read_ctrl (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .div_i (div_i),
        .echo_en_i (echo_en_i), .sdata_i (sdata_i), .cs_n_o (cs_n_o),
        .sclk_o (sclk_o), .result_o (result_o), .result_sx_o (result_sx_o),
        .valid_o (valid_o), .err_o (err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int errs = 0;
    int checks = 0;
    int cyc = 0;
    int rise_total = 0;
    int hi_total = 0;
    int valid_total = 0;

    // converter model
    logic [11:0] dev_word = '0;
    logic        dev_bad = 1'b0;
    logic        dev_flip = 1'b0;
    int          fcnt = 0;

    always @(negedge sclk_o or posedge cs_n_o) begin
        if (cs_n_o) begin
            fcnt = 0;
            sdata_i = 1'b1;
        end else begin
            fcnt = fcnt + 1;
            if (fcnt == 2)                      sdata_i = dev_bad;
            else if (fcnt >= 3 && fcnt <= 14)   sdata_i = dev_word[14-fcnt];
            else if (fcnt >= 15 && fcnt <= 25)  sdata_i = dev_word[fcnt-14] ^ (dev_flip && fcnt == 19);
            else if (fcnt > 25)                 sdata_i = 1'b0;
        end
    end

    always @(posedge sclk_o) rise_total++;
    always @(posedge clk) begin
        cyc++;
        if (sclk_o) hi_total++;
        if (valid_o) valid_total++;
        if (cyc > 150000) begin
            errs++; checks++;
            $display("FAIL R2 watchdog: cycles=%0d expected below %0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_valid();
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            if (valid_o) break;
        end
    endtask

    task automatic do_read(input logic [11:0] w, input int dv, input logic ec,
                           input logic bad, input logic flip, input logic experr);
        int r0, h0;
        logic [11:0] held;
        dev_word = w; dev_bad = bad; dev_flip = flip;
        @(negedge clk);
        r0 = rise_total; h0 = hi_total;
        start_i = 1'b1; div_i = DIV_W'(dv); echo_en_i = ec;
        @(negedge clk);
        start_i = 1'b0; div_i = '0; echo_en_i = 1'b0;
        check("R2", "cs low after start", {31'd0, cs_n_o}, 32'd0);
        wait_valid();
        check("R8", "valid seen", {31'd0, valid_o}, 32'd1);
        check("R8", "cs high at valid", {31'd0, cs_n_o}, 32'd1);
        check("R3", "sclk low at valid", {31'd0, sclk_o}, 32'd0);
        check("R5", "result", {20'd0, result_o}, {20'd0, w});
        check("R7", "sign ext", {16'd0, result_sx_o}, {16'd0, {4{w[11]}}, w});
        check(ec ? "R6" : "R4", "error flag", {31'd0, err_o}, {31'd0, experr});
        check("R6", "rising edges", 32'(rise_total - r0), ec ? 32'd26 : 32'd15);
        check("R3", "high cycles", 32'(hi_total - h0), 32'((ec ? 26 : 15) * (dv + 1)));
        held = result_o;
        @(negedge clk);
        check("R8", "valid one cycle", {31'd0, valid_o}, 32'd0);
        check("R8", "result held", {20'd0, result_o}, {20'd0, held});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "cs_n in reset", {31'd0, cs_n_o}, 32'd1);
        check("R1", "sclk in reset", {31'd0, sclk_o}, 32'd0);
        check("R1", "valid in reset", {31'd0, valid_o}, 32'd0);
        check("R1", "err in reset", {31'd0, err_o}, 32'd0);
        check("R1", "result in reset", {16'd0, result_sx_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "cs_n after reset", {31'd0, cs_n_o}, 32'd1);

        for (int i = 0; i < NVEC; i++) begin
            do_read(VEC[i][11:0], int'(VEC[i][13:12]), VEC[i][14],
                    VEC[i][15], VEC[i][16], VEC[i][17]);
            repeat (3) @(negedge clk);
        end

        // R2: start during a read is ignored
        begin
            int v0;
            v0 = valid_total;
            dev_word = 12'h6B1; dev_bad = 1'b0; dev_flip = 1'b0;
            start_i = 1'b1; div_i = 4'd1; echo_en_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            repeat (20) @(negedge clk);
            start_i = 1'b1; div_i = 4'd0; echo_en_i = 1'b0;
            @(negedge clk);
            start_i = 1'b0;
            check("R2", "cs stays low on busy start", {31'd0, cs_n_o}, 32'd0);
            wait_valid();
            check("R6", "echo read result", {20'd0, result_o}, 32'h6B1);
            check("R6", "echo read no error", {31'd0, err_o}, 32'd0);
            repeat (200) @(negedge clk);
            check("R2", "single valid", 32'(valid_total - v0), 32'd1);
            check("R2", "cs high when idle", {31'd0, cs_n_o}, 32'd1);
            check("R8", "result held idle", {20'd0, result_o}, 32'h6B1);
        end

        // R4 marker high with echo disabled and largest divider
        do_read(12'h001, 15, 1'b0, 1'b1, 1'b0, 1'b1);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule